// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block guards physical memory with sixteen programmable regions. Machine-level software writes a per-region address register and a per-region configuration byte through a simple register port. Each configuration register packs four of those bytes. Every cycle the block takes one physical byte address, an access kind (read, write or execute) and the privilege level of the requester. It returns a single allow or deny answer, which is combinational from the check inputs.

Each region selects one of four address-matching modes: disabled, top-of-range, a single aligned 4-byte word, or an aligned power-of-two block of 8 bytes or more. When several regions cover an address, the region with the lowest index decides the answer. A region can be locked. Locking freezes its registers until reset, and it also makes the region's permissions apply to machine mode. The checker is meant to sit beside a load/store or fetch path, and the core's control-register logic drives it.

Top module: `pmp_checker`

## Requirements
- R1: After reset every address register and configuration byte reads back as zero, and no region is enabled, so every access at every privilege is allowed.
- R2: Configuration register k (csr_is_addr=0, csr_idx=k) holds the bytes of regions 4k to 4k+3, with region 4k+j in bits [8j+7:8j]. Within a byte, bit 7 is the lock, bits 6:5 are reserved, bits 4:3 are the mode (0 off, 1 top-of-range, 2 aligned word, 3 power-of-two block), bit 2 is execute, bit 1 is write and bit 0 is read. The reserved bits always read back as zero, whatever is written.
- R3: Address register i (csr_is_addr=1, csr_idx=i) stores bits [33:2] of a physical address and reads back unchanged while it is writable.
- R4: While a region's lock bit is set, writes to its configuration byte and to its address register are ignored. The other bytes in the same configuration register still take the write.
- R5: While region i+1 is locked in top-of-range mode, writes to address register i are also ignored.
- R6: A top-of-range region i matches when addr[i-1] <= access[33:2] < addr[i]. Region 0 uses zero as its lower bound.
- R7: An aligned-word region matches exactly the four bytes whose access[33:2] equals its address register.
- R8: A power-of-two region whose address register ends in t ones covers 2^(t+3) bytes. Its base is the register with its low t+1 bits cleared, times four.
- R9: When several regions match, only the lowest-numbered one decides the result.
- R10: For privilege codes 0 to 2, a matching region allows the access only if its permission bit for the kind is set. chk_kind uses 0 for read, 1 for write and 2 for execute; 3 grants nothing.
- R11: For privilege code 3 (machine), an unlocked matching region always allows the access, and a locked matching region applies its permission bits.
- R12: When no region matches, machine mode is allowed. Lower privileges are denied if any region is enabled, and allowed otherwise.
- R13: A region whose mode is 0 never matches, even though its address register still serves as the lower bound of the region above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_is_addr | input | 1 | 1 selects address registers, 0 selects configuration registers |
| csr_idx | input | 4 | Register index |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the selected register (combinational) |
| chk_addr | input | 34 | Physical byte address to check |
| chk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| chk_priv | input | 2 | Privilege level, 3 is machine |
| chk_allow | output | 1 | 1 when the access is permitted |

## Verification
A corrupted address or configuration byte shows up on csr_rdata on the read right after the write. In the same cycle it also moves the allow/deny boundary for any address near that region. A broken priority, mask or comparison changes chk_allow combinationally for the very access that exercises it. This is why the sweeps compare every byte address of a programmed window, for every kind and privilege, against a model that derives region bounds arithmetically. A lock that fails to hold is caught by reading back the register right after the rejected write.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  // Bit order is architectural: software decodes these positions.
  typedef struct packed {
    logic       lock;
    logic [1:0] rsv;
    amode_e     amode;
    logic       x;
    logic       w;
    logic       r;
  } cfg_t;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  // Reserved field is forced to zero on every write.
  function automatic cfg_t legalize_cfg(input logic [7:0] raw);
    cfg_t c;
    c = cfg_t'(raw);
    c.rsv = 2'b00;
    return c;
  endfunction

  function automatic logic perm_granted(input cfg_t c, input logic [1:0] kind);
    case (kind)
      2'd0:    return c.r;
      2'd1:    return c.w;
      2'd2:    return c.x;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pmp_regfile.sv
module pmp_regfile
  import pmp_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int XLEN        = 32,
  parameter int AREG_W      = 32,
  parameter int IDX_W       = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 csr_we,
  input  logic                                 csr_is_addr,
  input  logic [IDX_W-1:0]                     csr_idx,
  input  logic [XLEN-1:0]                      csr_wdata,
  output logic [XLEN-1:0]                      csr_rdata,
  output cfg_t [NUM_REGIONS-1:0]               cfg_o,
  output logic [NUM_REGIONS-1:0][AREG_W-1:0]   addr_o,
  output logic [NUM_REGIONS-1:0]               cfg_lock_o,
  output logic [NUM_REGIONS-1:0]               addr_lock_o
);

  localparam int PER_REG = XLEN / 8;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    cfg_t              cfg_r;
    logic [AREG_W-1:0] addr_r;
    logic              tor_above;
    logic              cfg_wr;
    logic              addr_wr;

    if (i < NUM_REGIONS - 1) begin : g_up
      assign tor_above = cfg_o[i+1].lock && (cfg_o[i+1].amode == AM_TOR);
    end else begin : g_top
      assign tor_above = 1'b0;
    end

    assign cfg_lock_o[i]  = cfg_r.lock;
    assign addr_lock_o[i] = cfg_r.lock | tor_above;

    assign cfg_wr  = csr_we && !csr_is_addr && (csr_idx == IDX_W'(i / PER_REG)) && !cfg_r.lock;
    assign addr_wr = csr_we &&  csr_is_addr && (csr_idx == IDX_W'(i)) && !addr_lock_o[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_r  <= '0;
        addr_r <= '0;
      end else begin
        if (cfg_wr)  cfg_r  <= legalize_cfg(csr_wdata[8*(i%PER_REG) +: 8]);
        if (addr_wr) addr_r <= csr_wdata[AREG_W-1:0];
      end
    end

    assign cfg_o[i]  = cfg_r;
    assign addr_o[i] = addr_r;
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_is_addr) begin
      csr_rdata[AREG_W-1:0] = addr_o[csr_idx];
    end else begin
      for (int j = 0; j < PER_REG; j++) begin
        if (int'(csr_idx) * PER_REG + j < NUM_REGIONS)
          csr_rdata[8*j +: 8] = cfg_o[IDX_W'(int'(csr_idx) * PER_REG + j)];
      end
    end
  end

endmodule

// File: rtl/pmp_match.sv
module pmp_match
  import pmp_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int AREG_W      = 32
) (
  input  cfg_t [NUM_REGIONS-1:0]             cfg_i,
  input  logic [NUM_REGIONS-1:0][AREG_W-1:0] addr_i,
  input  logic [AREG_W-1:0]                  word_i,
  output logic [NUM_REGIONS-1:0]             hit_o
);

  // Bits that take part in the comparison: all but the trailing ones
  // and the zero just above them.
  function automatic logic [AREG_W-1:0] napot_keep(input logic [AREG_W-1:0] a);
    return ~(a ^ (a + AREG_W'(1)));
  endfunction

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
    logic [AREG_W-1:0] base;
    logic              h;

    if (i == 0) begin : g_zero
      assign base = '0;
    end else begin : g_prev
      assign base = addr_i[i-1];
    end

    always_comb begin
      h = 1'b0;
      case (cfg_i[i].amode)
        AM_TOR:   h = (word_i >= base) && (word_i < addr_i[i]);
        AM_NA4:   h = (word_i == addr_i[i]);
        AM_NAPOT: h = ((word_i ^ addr_i[i]) & napot_keep(addr_i[i])) == '0;
        default:  h = 1'b0;
      endcase
    end

    assign hit_o[i] = h;
  end

endmodule

// File: rtl/pmp_prio.sv
module pmp_prio #(
  parameter int NUM_REGIONS = 16,
  parameter int IDX_W       = 4
) (
  input  logic [NUM_REGIONS-1:0] hit_i,
  output logic [NUM_REGIONS-1:0] win_oh_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output logic                   any_hit_o
);

  assign win_oh_o  = hit_i & (~hit_i + NUM_REGIONS'(1));
  assign any_hit_o = |hit_i;

  always_comb begin
    win_idx_o = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_i[i]) win_idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int XLEN        = 32,
  parameter int PA_W        = 34,
  localparam int AREG_W     = PA_W - 2,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic             csr_is_addr,
  input  logic [IDX_W-1:0] csr_idx,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  input  logic [PA_W-1:0]  chk_addr,
  input  logic [1:0]       chk_kind,
  input  logic [1:0]       chk_priv,
  output logic             chk_allow
);

  cfg_t [NUM_REGIONS-1:0]             cfg;
  logic [NUM_REGIONS-1:0][AREG_W-1:0] addr;
  logic [NUM_REGIONS-1:0]             cfg_lock;
  logic [NUM_REGIONS-1:0]             addr_lock;
  logic [NUM_REGIONS-1:0]             hit;
  logic [NUM_REGIONS-1:0]             win_oh;
  logic [NUM_REGIONS-1:0]             enabled;
  logic [IDX_W-1:0]                   win_idx;
  logic                               any_hit;
  logic                               any_enabled;
  logic [8*NUM_REGIONS-1:0]           cfg_flat;
  logic [AREG_W*NUM_REGIONS-1:0]      addr_flat;
  cfg_t                               win_cfg;
  logic                               win_perm;
  logic                               is_machine;

  pmp_regfile #(
    .NUM_REGIONS(NUM_REGIONS), .XLEN(XLEN), .AREG_W(AREG_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_is_addr(csr_is_addr), .csr_idx(csr_idx),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cfg_o(cfg), .addr_o(addr), .cfg_lock_o(cfg_lock), .addr_lock_o(addr_lock)
  );

  pmp_match #(.NUM_REGIONS(NUM_REGIONS), .AREG_W(AREG_W)) u_match (
    .cfg_i(cfg), .addr_i(addr), .word_i(chk_addr[PA_W-1:2]), .hit_o(hit)
  );

  pmp_prio #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_prio (
    .hit_i(hit), .win_oh_o(win_oh), .win_idx_o(win_idx), .any_hit_o(any_hit)
  );

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_en
    assign enabled[i] = (cfg[i].amode != AM_OFF);
  end

  assign any_enabled = |enabled;
  assign cfg_flat    = cfg;
  assign addr_flat   = addr;
  assign win_cfg     = cfg[win_idx];
  assign win_perm    = perm_granted(win_cfg, chk_kind);
  assign is_machine  = (chk_priv == PRIV_MACHINE);

  always_comb begin
    if (any_hit) chk_allow = (is_machine && !win_cfg.lock) || win_perm;
    else         chk_allow = is_machine || !any_enabled;
  end

endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva #(
  parameter int NUM_REGIONS = 16,
  parameter int XLEN        = 32,
  parameter int AREG_W      = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          csr_is_addr,
  input logic [XLEN-1:0]               csr_rdata,
  input logic [1:0]                    chk_priv,
  input logic                          chk_allow,
  input logic                          any_hit,
  input logic                          any_enabled,
  input logic [NUM_REGIONS-1:0]        win_oh,
  input logic [NUM_REGIONS-1:0]        cfg_lock,
  input logic [NUM_REGIONS-1:0]        addr_lock,
  input logic [8*NUM_REGIONS-1:0]      cfg_flat,
  input logic [AREG_W*NUM_REGIONS-1:0] addr_flat
);

  localparam logic [XLEN-1:0] RSV_MASK = {(XLEN/8){8'h60}};

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_lock
    assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lock[i] |=> $stable(cfg_flat[8*i +: 8]))
      else $error("locked configuration byte changed");

    // covers R4 and the neighbour protection of R5
    assert_addr_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      addr_lock[i] |=> $stable(addr_flat[AREG_W*i +: AREG_W]))
      else $error("protected address register changed");
  end

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_is_addr |-> ((csr_rdata & RSV_MASK) == '0))
    else $error("reserved configuration bits read nonzero");

  assert_single_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && (any_hit == (win_oh != '0)))
    else $error("winner vector inconsistent");

  assert_m_default_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_priv == 2'b11 && !any_hit) |-> chk_allow)
    else $error("machine access without match denied");

  assert_low_default_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_priv != 2'b11 && !any_hit && any_enabled) |-> !chk_allow)
    else $error("lower-privilege access without match allowed");

  assert_m_unlocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_priv == 2'b11 && any_hit && ((win_oh & cfg_lock) == '0)) |-> chk_allow)
    else $error("machine access to unlocked region denied");

endmodule

bind pmp_checker pmp_checker_sva #(
  .NUM_REGIONS(NUM_REGIONS), .XLEN(XLEN), .AREG_W(AREG_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .csr_is_addr(csr_is_addr), .csr_rdata(csr_rdata),
  .chk_priv(chk_priv), .chk_allow(chk_allow), .any_hit(any_hit),
  .any_enabled(any_enabled), .win_oh(win_oh), .cfg_lock(cfg_lock),
  .addr_lock(addr_lock), .cfg_flat(cfg_flat), .addr_flat(addr_flat)
);

// File: tb/pmp_checker_tb.sv
module pmp_checker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic        csr_is_addr = 1'b0;
  logic [3:0]  csr_idx = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [33:0] chk_addr = '0;
  logic [1:0]  chk_kind = '0;
  logic [1:0]  chk_priv = '0;
  logic        chk_allow;

  int total = 0;
  int bad   = 0;

  logic [7:0]  bcfg  [16];
  logic [31:0] baddr [16];

  always #2 clk = ~clk;

  pmp_checker u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_is_addr(csr_is_addr),
    .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .chk_addr(chk_addr), .chk_kind(chk_kind), .chk_priv(chk_priv),
    .chk_allow(chk_allow)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model of register writes, from the lock rules R2, R4 and R5.
  task automatic csr_wr(input bit is_a, input int idx, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_is_addr = is_a; csr_idx = idx[3:0]; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
    if (is_a) begin
      if (!bcfg[idx][7] && !(idx < 15 && bcfg[idx+1][7] && bcfg[idx+1][4:3] == 2'd1))
        baddr[idx] = d;
    end else begin
      for (int j = 0; j < 4; j++)
        if (!bcfg[idx*4+j][7]) bcfg[idx*4+j] = d[8*j +: 8] & 8'h9F;
    end
  endtask

  task automatic csr_rd(input bit is_a, input int idx, output logic [31:0] v);
    @(negedge clk);
    csr_is_addr = is_a; csr_idx = idx[3:0];
    #1 v = csr_rdata;
  endtask

  // Region bounds derived from size and base arithmetic (R6, R7, R8, R13).
  function automatic bit model(input logic [33:0] a, input int kind, input int priv);
    longint unsigned w, lo, hi, sz;
    int  t;
    bit  hit, en;
    w  = longint'(a >> 2);
    en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      hit = 1'b0;
      if (bcfg[i][4:3] != 2'd0) en = 1'b1;
      case (bcfg[i][4:3])
        2'd1: begin
          lo  = (i == 0) ? 0 : longint'(baddr[i-1]);
          hi  = longint'(baddr[i]);
          hit = (w >= lo) && (w < hi);
        end
        2'd2: hit = (w == longint'(baddr[i]));
        2'd3: begin
          t = 0;
          while (t < 32 && baddr[i][t]) t++;
          sz  = 64'd1 << (t + 1);
          lo  = (longint'(baddr[i]) / sz) * sz;
          hit = (w >= lo) && (w < lo + sz);
        end
        default: hit = 1'b0;
      endcase
      if (hit) begin
        if (priv == 3 && !bcfg[i][7]) return 1'b1;
        return (kind < 3) ? bcfg[i][kind] : 1'b0;
      end
    end
    if (priv == 3) return 1'b1;
    return !en;
  endfunction

  task automatic probe(input string tag, input logic [33:0] a, input int kind,
                       input int priv, input bit exp);
    @(negedge clk);
    chk_addr = a; chk_kind = kind[1:0]; chk_priv = priv[1:0];
    #1 check(tag, {63'd0, chk_allow}, {63'd0, exp});
  endtask

  task automatic sweep(input string tag, input logic [33:0] lo, input int n);
    for (int k = 0; k < n; k++)
      for (int kind = 0; kind < 3; kind++)
        for (int pi = 0; pi < 3; pi++) begin
          int p;
          p = (pi == 2) ? 3 : pi;
          probe(tag, lo + 34'(k), kind, p, model(lo + 34'(k), kind, p));
        end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin bcfg[i] = '0; baddr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      csr_rd(1'b1, i, v); check("R1 addr reset", v, 0);
    end
    for (int i = 0; i < 4; i++) begin
      csr_rd(1'b0, i, v); check("R1 cfg reset", v, 0);
    end
    probe("R1 user read open", 34'h100, 0, 0, 1'b1);
    probe("R1 user exec open", 34'h3_0000_0000, 2, 1, 1'b1);

    // Config A: TOR, NA4, NAPOT, OFF, TOR, overlapping NAPOT
    csr_wr(1'b1, 0, 32'h10);
    csr_wr(1'b1, 1, 32'h14);
    csr_wr(1'b1, 2, 32'h23);
    csr_wr(1'b1, 3, 32'h30);
    csr_wr(1'b1, 4, 32'h38);
    csr_wr(1'b1, 5, 32'h0F);
    csr_wr(1'b0, 0, 32'h001C_1309);
    csr_wr(1'b0, 1, 32'h0000_1B0F);
    csr_rd(1'b1, 2, v); check("R3 addr readback", v, 32'h23);
    csr_rd(1'b0, 1, v); check("R2 cfg packing", v, 32'h0000_1B0F);

    probe("R9 region0 beats region5 on write", 34'h20, 1, 0, 1'b0);
    probe("R9 region5 below NA4", 34'h40, 1, 0, 1'b1);
    probe("R7 NA4 write hit", 34'h53, 1, 1, 1'b1);
    probe("R8 NAPOT exec inside", 34'h9C, 2, 0, 1'b1);
    probe("R8 NAPOT exec just past", 34'hA0, 2, 0, 1'b0);
    probe("R13 off region no match", 34'hB4, 0, 0, 1'b0);
    probe("R6 TOR upper bound", 34'hDF, 2, 1, 1'b1);
    probe("R6 TOR end excluded", 34'hE0, 2, 1, 1'b0);
    probe("R11 machine unlocked", 34'h20, 1, 3, 1'b1);
    probe("R12 machine no match", 34'hE0, 0, 3, 1'b1);
    // R6 R7 R8 R9 R10 R11 R12 R13 all at once
    sweep("R10 sweep unlocked", 34'h0, 288);

    // Config B: lock regions 0 and 4
    csr_wr(1'b0, 0, 32'h001C_1389);
    csr_wr(1'b0, 1, 32'h0000_1B8F);
    probe("R11 machine locked write denied", 34'h20, 1, 3, 1'b0);
    probe("R11 machine locked read allowed", 34'h20, 0, 3, 1'b1);
    sweep("R11 sweep locked", 34'h0, 288);

    csr_wr(1'b1, 0, 32'h55);
    csr_rd(1'b1, 0, v); check("R4 locked addr ignored", v, 32'h10);
    csr_wr(1'b0, 0, 32'h0000_0000);
    csr_rd(1'b0, 0, v); check("R4 locked byte kept, others written", v, 32'h0000_0089);
    csr_wr(1'b1, 3, 32'h77);
    csr_rd(1'b1, 3, v); check("R5 addr below locked TOR ignored", v, 32'h30);
    csr_wr(1'b1, 5, 32'h3F);
    csr_rd(1'b1, 5, v); check("R3 unlocked addr written", v, 32'h3F);

    csr_wr(1'b0, 3, 32'hFFFF_FFFF);
    csr_rd(1'b0, 3, v); check("R2 reserved bits read zero", v, 32'h9F9F_9F9F);
    csr_wr(1'b0, 3, 32'h0000_0000);
    csr_rd(1'b0, 3, v); check("R4 locked cfg register unchanged", v, 32'h9F9F_9F9F);
    sweep("R10 sweep after edits", 34'h0, 288);

    // Whole-space NAPOT on region 11, high addresses
    csr_wr(1'b1, 11, 32'hFFFF_FFFF);
    csr_rd(1'b1, 11, v); check("R3 all-ones addr", v, 32'hFFFF_FFFF);
    csr_wr(1'b0, 2, 32'h1900_0000);
    probe("R8 whole-space read", 34'h3_FFFF_FFFC, 0, 0, 1'b1);
    probe("R8 whole-space write denied", 34'h3_FFFF_FFFC, 1, 1, 1'b0);
    sweep("R8 sweep high", 34'h3_FFFF_FF00, 256);
    sweep("R9 sweep low with catch-all", 34'h0, 256);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule